// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block sits beside the command bus of a four-bank single-data-rate SDRAM and checks every decoded command against the minimum spacings it needs from earlier commands. It does not drive the bus. Each cycle it takes one command, the bank index, and the current CAS latency and burst length. It keeps elapsed-cycle counters for each bank and for the whole device. When a command arrives too early, it raises a one-cycle violation flag with a code that names the broken rule. It also flags a row that stays open past the maximum active time.

The limits are given as parameters in picoseconds, with one set for the fast speed grade and one for the slow grade, plus a clock period. At elaboration each limit becomes a cycle count by dividing it by the period and rounding up. The rules that concern write recovery and burst stop count from the last write data beat. The last beat falls on the write cycle plus the burst length minus one. The earliest precharge after a read depends on CAS latency plus burst length.

Top module: `sdram_cmd_timing_chk`

## Requirements
- R1: After reset all banks are closed and no counter history exists, so `viol_o` stays low on NOP cycles. A read or write to any bank is flagged as a bank-state error.
- R2: Limits are rounded up to whole cycles. With the defaults (7.5 ns clock, fast grade) this gives RRD = RCD = RP = 2, RAS = 7, RC = 9, RFC = 11 and RAS-max = 13334 cycles. A gap of g cycles between two commands satisfies a limit N when g >= N.
- R3: The command encoding on `cmd_i` is NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5, REF=6, MRS=7, BST=8. `cas_lat_i` holds 2 or 3. `burst_len_i` holds the beat count, from 1 to 8. For a command sampled on a clock edge, `viol_o` and `viol_code_o` are valid after that same edge for exactly that cycle. When no rule fails, `viol_o` is low and the code is 0.
- R4: When several rules fail in the same cycle, the lowest code number is reported.
- R5: Any command other than NOP sent fewer than RFC cycles after a refresh gives code 1.
- R6: An ACT or REF sent fewer than 2 cycles after an MRS gives code 2.
- R7: An ACT to an open bank, or a RD or WR to a closed bank, gives code 3. ACT opens a bank. PRE (to that bank) or PREA closes it.
- R8: An ACT sent fewer than RP cycles after its bank was closed gives code 4. An ACT sent fewer than RC cycles after the previous ACT to the same bank gives code 5. An ACT sent fewer than RRD cycles after an ACT to a different bank gives code 6.
- R9: A RD or WR sent fewer than RCD cycles after its bank's ACT gives code 7. Closing an open bank fewer than RAS cycles after its ACT gives code 8.
- R10: Let L be the last write beat. A RD or WR at or before L + 0 (less than 1 cycle after L) gives code 9. A precharge of the written bank, or a PREA, less than 2 cycles after L gives code 10. A BST less than 1 cycle after L gives code 11. Writes with a burst length of 1 may issue every cycle with no flag.
- R11: A PRE to the last-read bank, or a PREA, fewer than CL + BL - 2 cycles after that read gives code 12. CL and BL are the values in force when the read was issued.
- R12: A bank left open gives one pulse of code 13 in the cycle its open time reaches RAS-max + 1 cycles. A precharge at exactly RAS-max cycles gives no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 4 | Decoded command (encoding in R3) |
| bank_i | input | 2 | Bank index of the command |
| cas_lat_i | input | 2 | CAS latency in cycles |
| burst_len_i | input | 4 | Burst length in beats |
| viol_o | output | 1 | One-cycle violation flag |
| viol_code_o | output | 4 | Number of the broken rule, 0 when none |

## Verification
On every cycle, the embedded assertions check several properties. The elapsed counters step by one, ACT and precharge move each bank's open state, and the row-open-too-long flag never lasts two cycles. Any rule hit produces the flag on the next edge with the lowest code, and a cycle with no hit produces no flag. A few fixed two-command patterns also must trip their rule: refresh then a command, MRS then ACT, and a multi-beat write then burst stop. The exact cycle counts need the bench's gap sweeps, which cover every limit on both sides of its boundary, every burst length and CAS latency combination for write recovery and read-to-precharge, and the open-row limit at its exact edge. Only the bench can show these.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_PREA = 4'd5,
    CMD_REF  = 4'd6,
    CMD_MRS  = 4'd7,
    CMD_BST  = 4'd8
  } cmd_e;

  localparam int unsigned RULE_RFC    = 1;
  localparam int unsigned RULE_MRD    = 2;
  localparam int unsigned RULE_STATE  = 3;
  localparam int unsigned RULE_RP     = 4;
  localparam int unsigned RULE_RC     = 5;
  localparam int unsigned RULE_RRD    = 6;
  localparam int unsigned RULE_RCD    = 7;
  localparam int unsigned RULE_RAS    = 8;
  localparam int unsigned RULE_CDL    = 9;
  localparam int unsigned RULE_RDL    = 10;
  localparam int unsigned RULE_BDL    = 11;
  localparam int unsigned RULE_RTP    = 12;
  localparam int unsigned RULE_RASMAX = 13;
  localparam int unsigned RULE_LAST   = 13;

  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/sdram_since_ctr.sv
module sdram_since_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  output logic         valid_o,
  output logic [W-1:0] cnt_o
);
  logic         valid_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (hit_i) begin
      valid_q <= 1'b1;
      cnt_q   <= W'(1);
    end else if (valid_q && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign cnt_o   = cnt_q;

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !hit_i && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (valid_q && cnt_q == W'(1)));
endmodule

// File: rtl/sdram_bank_trk.sv
module sdram_bank_trk
  import sdram_chk_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned RP_C      = 2,
  parameter int unsigned RC_C      = 9,
  parameter int unsigned RCD_C     = 2,
  parameter int unsigned RAS_C     = 7,
  parameter int unsigned RAS_MAX_C = 13334
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic sel_i,
  output logic hit_state_o,
  output logic hit_rp_o,
  output logic hit_rc_o,
  output logic hit_rcd_o,
  output logic hit_ras_o,
  output logic hit_rasmax_o
);
  localparam logic [W-1:0] RP_W    = W'(RP_C);
  localparam logic [W-1:0] RC_W    = W'(RC_C);
  localparam logic [W-1:0] RCD_W   = W'(RCD_C);
  localparam logic [W-1:0] RAS_W   = W'(RAS_C);
  localparam logic [W-1:0] RASMX_W = W'(RAS_MAX_C + 1);

  logic         open_q;
  logic         is_act, is_col, is_pre;
  logic         act_v, pre_v;
  logic [W-1:0] act_cnt, pre_cnt;

  assign is_act = sel_i && cmd_i == CMD_ACT;
  assign is_col = sel_i && (cmd_i == CMD_RD || cmd_i == CMD_WR);
  assign is_pre = (sel_i && cmd_i == CMD_PRE) || cmd_i == CMD_PREA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_q <= 1'b0;
    else if (is_act) open_q <= 1'b1;
    else if (is_pre) open_q <= 1'b0;
  end

  sdram_since_ctr #(.W(W)) u_act_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(is_act), .valid_o(act_v), .cnt_o(act_cnt));

  // only a real close restarts the precharge window
  sdram_since_ctr #(.W(W)) u_pre_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(is_pre && open_q), .valid_o(pre_v), .cnt_o(pre_cnt));

  assign hit_state_o  = (is_act && open_q) || (is_col && !open_q);
  assign hit_rp_o     = is_act && pre_v && pre_cnt < RP_W;
  assign hit_rc_o     = is_act && act_v && act_cnt < RC_W;
  assign hit_rcd_o    = is_col && open_q && act_cnt < RCD_W;
  assign hit_ras_o    = is_pre && open_q && act_cnt < RAS_W;
  assign hit_rasmax_o = open_q && act_cnt == RASMX_W;

  a_r7_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |=> open_q);
  a_r7_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |=> !open_q);
  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_rasmax_o |=> !hit_rasmax_o);
endmodule

// File: rtl/sdram_glob_trk.sv
module sdram_glob_trk
  import sdram_chk_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned RRD_C  = 2,
  parameter int unsigned RFC_C  = 11,
  parameter int unsigned MRD_C  = 2,
  parameter int unsigned CDL_C  = 1,
  parameter int unsigned RDL_C  = 2,
  parameter int unsigned BDL_C  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [1:0]        cas_lat_i,
  input  logic [3:0]        burst_len_i,
  output logic              hit_rfc_o,
  output logic              hit_mrd_o,
  output logic              hit_rrd_o,
  output logic              hit_cdl_o,
  output logic              hit_rdl_o,
  output logic              hit_bdl_o,
  output logic              hit_rtp_o
);
  localparam logic [W-1:0] RRD_W = W'(RRD_C);
  localparam logic [W-1:0] RFC_W = W'(RFC_C);
  localparam logic [W-1:0] MRD_W = W'(MRD_C);
  localparam logic [W-1:0] CDL_W = W'(CDL_C);
  localparam logic [W-1:0] RDL_W = W'(RDL_C);
  localparam logic [W-1:0] BDL_W = W'(BDL_C);

  logic              act_v, ref_v, mrs_v, wr_v, rd_v;
  logic [W-1:0]      act_cnt, ref_cnt, mrs_cnt, wr_cnt, rd_cnt;
  logic [BANK_W-1:0] act_bank_q, wr_bank_q, rd_bank_q;
  logic [W-1:0]      wr_last_q;   // beats after the write command: BL-1
  logic [W-1:0]      rd_span_q;   // CL+BL-2
  logic              is_act, is_rd, is_wr, is_ref, is_mrs;
  logic              pre_wr_bank, pre_rd_bank;

  assign is_act = cmd_i == CMD_ACT;
  assign is_rd  = cmd_i == CMD_RD;
  assign is_wr  = cmd_i == CMD_WR;
  assign is_ref = cmd_i == CMD_REF;
  assign is_mrs = cmd_i == CMD_MRS;

  sdram_since_ctr #(.W(W)) u_act_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(is_act), .valid_o(act_v), .cnt_o(act_cnt));
  sdram_since_ctr #(.W(W)) u_ref_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(is_ref), .valid_o(ref_v), .cnt_o(ref_cnt));
  sdram_since_ctr #(.W(W)) u_mrs_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(is_mrs), .valid_o(mrs_v), .cnt_o(mrs_cnt));
  sdram_since_ctr #(.W(W)) u_wr_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(is_wr), .valid_o(wr_v), .cnt_o(wr_cnt));
  sdram_since_ctr #(.W(W)) u_rd_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(is_rd), .valid_o(rd_v), .cnt_o(rd_cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_bank_q <= '0;
      wr_bank_q  <= '0;
      rd_bank_q  <= '0;
      wr_last_q  <= '0;
      rd_span_q  <= '0;
    end else begin
      if (is_act) act_bank_q <= bank_i;
      if (is_wr) begin
        wr_bank_q <= bank_i;
        wr_last_q <= W'(burst_len_i) - W'(1);
      end
      if (is_rd) begin
        rd_bank_q <= bank_i;
        rd_span_q <= W'(cas_lat_i) + W'(burst_len_i) - W'(2);
      end
    end
  end

  assign pre_wr_bank = (cmd_i == CMD_PRE && bank_i == wr_bank_q) || cmd_i == CMD_PREA;
  assign pre_rd_bank = (cmd_i == CMD_PRE && bank_i == rd_bank_q) || cmd_i == CMD_PREA;

  assign hit_rfc_o = ref_v && ref_cnt < RFC_W && cmd_i != CMD_NOP;
  assign hit_mrd_o = mrs_v && mrs_cnt < MRD_W && (is_act || is_ref);
  assign hit_rrd_o = is_act && act_v && bank_i != act_bank_q && act_cnt < RRD_W;
  assign hit_cdl_o = (is_rd || is_wr) && wr_v && wr_cnt < wr_last_q + CDL_W;
  assign hit_rdl_o = pre_wr_bank && wr_v && wr_cnt < wr_last_q + RDL_W;
  assign hit_bdl_o = cmd_i == CMD_BST && wr_v && wr_cnt < wr_last_q + BDL_W;
  assign hit_rtp_o = pre_rd_bank && rd_v && rd_cnt < rd_span_q;

  a_r5_ref_then_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref ##1 (cmd_i != CMD_NOP) |-> hit_rfc_o);
  a_r6_mrs_then_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs ##1 is_act |-> hit_mrd_o);
  a_r10_wr_then_bst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && burst_len_i > 4'd1) ##1 (cmd_i == CMD_BST) |-> hit_bdl_o);
endmodule

// File: rtl/sdram_cmd_timing_chk.sv
module sdram_cmd_timing_chk
  import sdram_chk_pkg::*;
#(
  parameter int unsigned CLK_PS       = 7500,
  parameter bit          FAST_GRADE   = 1'b1,
  parameter int unsigned NBANK        = 4,
  parameter int unsigned FAST_RRD_PS  = 15000,
  parameter int unsigned FAST_RCD_PS  = 15000,
  parameter int unsigned FAST_RP_PS   = 15000,
  parameter int unsigned FAST_RAS_PS  = 48000,
  parameter int unsigned FAST_RC_PS   = 63000,
  parameter int unsigned SLOW_RRD_PS  = 20000,
  parameter int unsigned SLOW_RCD_PS  = 20000,
  parameter int unsigned SLOW_RP_PS   = 20000,
  parameter int unsigned SLOW_RAS_PS  = 50000,
  parameter int unsigned SLOW_RC_PS   = 90000,
  parameter int unsigned RFC_PS       = 80000,
  parameter int unsigned RAS_MAX_PS   = 100000000,
  parameter int unsigned MRD_CYC      = 2,
  parameter int unsigned CDL_CYC      = 1,
  parameter int unsigned RDL_CYC      = 2,
  parameter int unsigned BDL_CYC      = 1,
  localparam int unsigned BANK_W      = $clog2(NBANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [1:0]        cas_lat_i,
  input  logic [3:0]        burst_len_i,
  output logic              viol_o,
  output logic [3:0]        viol_code_o
);
  localparam int unsigned RRD_C = ps_to_cyc(FAST_GRADE ? FAST_RRD_PS : SLOW_RRD_PS, CLK_PS);
  localparam int unsigned RCD_C = ps_to_cyc(FAST_GRADE ? FAST_RCD_PS : SLOW_RCD_PS, CLK_PS);
  localparam int unsigned RP_C  = ps_to_cyc(FAST_GRADE ? FAST_RP_PS  : SLOW_RP_PS,  CLK_PS);
  localparam int unsigned RAS_C = ps_to_cyc(FAST_GRADE ? FAST_RAS_PS : SLOW_RAS_PS, CLK_PS);
  localparam int unsigned RC_C  = ps_to_cyc(FAST_GRADE ? FAST_RC_PS  : SLOW_RC_PS,  CLK_PS);
  localparam int unsigned RFC_C = ps_to_cyc(RFC_PS, CLK_PS);
  localparam int unsigned RASMX_C = ps_to_cyc(RAS_MAX_PS, CLK_PS);
  localparam int unsigned W     = $clog2(RASMX_C + 2) + 1;

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [NBANK-1:0] b_state, b_rp, b_rc, b_rcd, b_ras, b_rasmax;
  logic             g_rfc, g_mrd, g_rrd, g_cdl, g_rdl, g_bdl, g_rtp;
  logic [RULE_LAST:1] hits;
  logic [3:0]       code_d;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sdram_bank_trk #(
      .W(W), .RP_C(RP_C), .RC_C(RC_C), .RCD_C(RCD_C), .RAS_C(RAS_C), .RAS_MAX_C(RASMX_C)
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (cmd),
      .sel_i       (bank_i == BANK_W'(b)),
      .hit_state_o (b_state[b]),
      .hit_rp_o    (b_rp[b]),
      .hit_rc_o    (b_rc[b]),
      .hit_rcd_o   (b_rcd[b]),
      .hit_ras_o   (b_ras[b]),
      .hit_rasmax_o(b_rasmax[b])
    );
  end

  sdram_glob_trk #(
    .W(W), .BANK_W(BANK_W), .RRD_C(RRD_C), .RFC_C(RFC_C), .MRD_C(MRD_CYC),
    .CDL_C(CDL_CYC), .RDL_C(RDL_CYC), .BDL_C(BDL_CYC)
  ) u_glob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .bank_i     (bank_i),
    .cas_lat_i  (cas_lat_i),
    .burst_len_i(burst_len_i),
    .hit_rfc_o  (g_rfc),
    .hit_mrd_o  (g_mrd),
    .hit_rrd_o  (g_rrd),
    .hit_cdl_o  (g_cdl),
    .hit_rdl_o  (g_rdl),
    .hit_bdl_o  (g_bdl),
    .hit_rtp_o  (g_rtp)
  );

  always_comb begin
    hits                = '0;
    hits[RULE_RFC]      = g_rfc;
    hits[RULE_MRD]      = g_mrd;
    hits[RULE_STATE]    = |b_state;
    hits[RULE_RP]       = |b_rp;
    hits[RULE_RC]       = |b_rc;
    hits[RULE_RRD]      = g_rrd;
    hits[RULE_RCD]      = |b_rcd;
    hits[RULE_RAS]      = |b_ras;
    hits[RULE_CDL]      = g_cdl;
    hits[RULE_RDL]      = g_rdl;
    hits[RULE_BDL]      = g_bdl;
    hits[RULE_RTP]      = g_rtp;
    hits[RULE_RASMAX]   = |b_rasmax;
  end

  // scan high to low so the lowest set rule wins
  always_comb begin
    code_d = '0;
    for (int i = RULE_LAST; i >= 1; i--) begin
      if (hits[i]) code_d = 4'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_code_o <= '0;
    end else begin
      viol_o      <= |hits;
      viol_code_o <= code_d;
    end
  end

  a_r3_flag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hits) |=> viol_o);
  a_r3_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|hits) |=> (!viol_o && viol_code_o == 4'd0));
  a_r4_rfc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hits[RULE_RFC] |=> viol_code_o == 4'(RULE_RFC));
  a_r4_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (viol_code_o != 4'd0 && viol_code_o <= 4'(RULE_LAST)));
endmodule

// File: tb/sim_sdram_cmd_timing_chk.sv
`timescale 1ns/1ps
module sim_sdram_cmd_timing_chk;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PS  = 7500;
  localparam int T_RRD   = (15000 + TCK_PS - 1) / TCK_PS;
  localparam int T_RCD   = (15000 + TCK_PS - 1) / TCK_PS;
  localparam int T_RP    = (15000 + TCK_PS - 1) / TCK_PS;
  localparam int T_RAS   = (48000 + TCK_PS - 1) / TCK_PS;
  localparam int T_RC    = (63000 + TCK_PS - 1) / TCK_PS;
  localparam int T_RFC   = (80000 + TCK_PS - 1) / TCK_PS;
  localparam int T_RASMX = (100000000 + TCK_PS - 1) / TCK_PS;

  localparam logic [3:0] NOP = 4'd0, ACT = 4'd1, RD = 4'd2, WR = 4'd3, PRE = 4'd4,
                         PREA = 4'd5, REF = 4'd6, MRS = 4'd7, BST = 4'd8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cmd = NOP;
  logic [1:0] bank = '0;
  logic [1:0] cl = 2'd2;
  logic [3:0] bl = 4'd1;
  logic       viol;
  logic [3:0] code;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_timing_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank),
    .cas_lat_i(cl), .burst_len_i(bl), .viol_o(viol), .viol_code_o(code));

  task automatic check(input string tag, input int exp);
    int act;
    act = viol ? int'(code) : 0;
    n_cmp++;
    if (act != exp || (exp == 0 && code != 4'd0)) begin
      n_bad++;
      $display("FAIL %s: code got %0d (flag %0b) expected %0d", tag, act, viol, exp);
    end
  endtask

  // call at a falling edge; exp < 0 skips the check
  task automatic drive(input logic [3:0] c, input int b, input int exp, input string tag);
    cmd = c;
    bank = 2'(b);
    @(posedge clk);
    #1;
    if (exp >= 0) check(tag, exp);
    @(negedge clk);
    cmd = NOP;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(NOP, 0, -1, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd = NOP;
    cl = 2'd2;
    bl = 4'd1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state
    do_reset();
    drive(NOP, 0, 0, "R1 idle after reset");
    drive(RD, 3, 3, "R1 read closed bank after reset");
    drive(WR, 1, 3, "R1/R7 write closed bank");

    // R5: refresh window, R2 RFC=11
    for (int g = 1; g <= T_RFC + 1; g++) begin
      do_reset();
      drive(REF, 0, 0, "R5 ref");
      idle(g - 1);
      drive(MRS, 0, (g < T_RFC) ? 1 : 0, $sformatf("R5 cmd %0d after ref", g));
    end

    // R6: mode register to act / ref
    for (int g = 1; g <= 3; g++) begin
      do_reset();
      drive(MRS, 0, 0, "R6 mrs");
      idle(g - 1);
      drive(ACT, 0, (g < 2) ? 2 : 0, $sformatf("R6 act %0d after mrs", g));
      do_reset();
      drive(MRS, 0, 0, "R6 mrs");
      idle(g - 1);
      drive(REF, 0, (g < 2) ? 2 : 0, $sformatf("R6 ref %0d after mrs", g));
    end

    // R4: priority
    do_reset();
    drive(REF, 0, 0, "R4 ref");
    idle(4);
    drive(MRS, 0, 1, "R4 mrs in rfc");
    drive(ACT, 0, 1, "R4 rfc beats mrd");
    do_reset();
    drive(ACT, 0, 0, "R4 act");
    idle(2);
    drive(ACT, 0, 3, "R4/R7 reopen beats rc");
    do_reset();
    drive(ACT, 0, 0, "R4 act b0");
    drive(ACT, 1, 6, "R8 rrd b1");
    drive(RD, 1, 7, "R9 rcd b1");

    // R8: RRD
    for (int g = 1; g <= T_RRD + 1; g++) begin
      do_reset();
      drive(ACT, 0, 0, "R8 act b0");
      idle(g - 1);
      drive(ACT, 2, (g < T_RRD) ? 6 : 0, $sformatf("R8 rrd gap %0d", g));
    end

    // R8: RP after a legal close
    for (int g = 1; g <= T_RP + 1; g++) begin
      do_reset();
      drive(ACT, 1, 0, "R8 act");
      idle(T_RAS - 1);
      drive(PRE, 1, 0, "R9 pre at ras");
      idle(g - 1);
      drive(ACT, 1, (g < T_RP) ? 4 : 0, $sformatf("R8 rp gap %0d", g));
    end

    // R8/R9: early close then RC
    for (int p = T_RP; p <= T_RAS; p++) begin
      do_reset();
      drive(ACT, 0, 0, "R8 act");
      idle(p - 1);
      drive(PRE, 0, (p < T_RAS) ? 8 : 0, $sformatf("R9 ras pre at %0d", p));
      idle(T_RP - 1);
      drive(ACT, 0, (p + T_RP < T_RC) ? 5 : 0, $sformatf("R8 rc act at %0d", p + T_RP));
    end
    do_reset();
    drive(ACT, 3, 0, "R9 act");
    idle(2);
    drive(PREA, 0, 8, "R9 prea before ras");

    // R9: RCD
    for (int g = 1; g <= T_RCD + 1; g++) begin
      do_reset();
      drive(ACT, 2, 0, "R9 act");
      idle(g - 1);
      drive(RD, 2, (g < T_RCD) ? 7 : 0, $sformatf("R9 rcd gap %0d", g));
    end

    // R10: write-beat rules over burst lengths
    for (int k = 0; k < 4; k++) begin
      int b;
      b = 1 << k;
      for (int g = 1; g <= b + 2; g++) begin
        do_reset();
        drive(ACT, 0, 0, "R10 act");
        idle(T_RAS - 1);
        bl = 4'(b);
        drive(WR, 0, 0, "R10 wr");
        idle(g - 1);
        drive(RD, 0, (g < b) ? 9 : 0, $sformatf("R10 cdl bl%0d gap %0d", b, g));

        do_reset();
        drive(ACT, 0, 0, "R10 act");
        idle(T_RAS - 1);
        bl = 4'(b);
        drive(WR, 0, 0, "R10 wr");
        idle(g - 1);
        drive(PRE, 0, (g < b + 1) ? 10 : 0, $sformatf("R10 rdl bl%0d gap %0d", b, g));

        do_reset();
        drive(ACT, 0, 0, "R10 act");
        idle(T_RAS - 1);
        bl = 4'(b);
        drive(WR, 0, 0, "R10 wr");
        idle(g - 1);
        drive(BST, 0, (g < b) ? 11 : 0, $sformatf("R10 bdl bl%0d gap %0d", b, g));
      end
    end
    do_reset();
    drive(ACT, 1, 0, "R10 act");
    idle(T_RCD - 1);
    bl = 4'd1;
    for (int i = 0; i < 4; i++) drive(WR, 1, 0, "R10 back-to-back wr bl1");
    for (int i = 0; i < 3; i++) drive(RD, 1, 0, "R10 back-to-back rd");

    // R11: read to precharge
    for (int c = 2; c <= 3; c++) begin
      for (int k = 0; k < 4; k++) begin
        int b;
        b = 1 << k;
        for (int g = 1; g <= c + b; g++) begin
          do_reset();
          drive(ACT, 1, 0, "R11 act");
          idle(T_RAS - 1);
          cl = 2'(c);
          bl = 4'(b);
          drive(RD, 1, 0, "R11 rd");
          cl = 2'd2;
          bl = 4'd1;
          idle(g - 1);
          drive(PRE, 1, (g < c + b - 2) ? 12 : 0,
                $sformatf("R11 rtp cl%0d bl%0d gap %0d", c, b, g));
        end
      end
    end
    do_reset();
    drive(ACT, 1, 0, "R11 act");
    idle(T_RAS - 1);
    cl = 2'd3;
    bl = 4'd8;
    drive(RD, 1, 0, "R11 rd");
    drive(PREA, 0, 12, "R11 prea early");

    // R12: row open too long
    do_reset();
    drive(ACT, 2, 0, "R12 act");
    idle(T_RASMX - 2);
    drive(NOP, 0, 0, "R12 at max-1");
    drive(NOP, 0, 0, "R12 at max");
    drive(NOP, 0, 13, "R12 past max");
    drive(NOP, 0, 0, "R12 single pulse");
    do_reset();
    drive(ACT, 2, 0, "R12 act");
    idle(T_RASMX - 1);
    drive(PRE, 2, 0, "R12 pre at max");
    drive(NOP, 0, 0, "R12 closed no flag");
    drive(NOP, 0, 0, "R12 closed no flag");

    summary();
  end
endmodule